// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor

This block is a small stored-program processor with one accumulator. Instructions and data share one 16-word memory inside the block. A control unit steps each instruction through fetch, decode and execute. Each step is a single register transfer per clock, through explicit program-counter, memory-address, memory-data, instruction and accumulator registers. Every memory access goes through the address and data registers, so each phase of an instruction can be seen cycle by cycle.

An instruction is 8 bits: the opcode in the upper four bits and a memory address in the lower four. There are four memory instructions (LOAD, ADD, SUB, STORE), a halt opcode, and a no-op for every other code. The memory is preloaded through a load port while reset is held. After reset is released the processor runs on its own until it halts. Each store it performs appears on a store strobe with its address and data.

Top module: `accum_cpu`

## Requirements
- R1: A synchronous reset clears the program counter, accumulator and internal address, data and instruction registers to zero. It deasserts `halted` and restarts at the first fetch step. No store strobe is raised while reset is held.
- R2: Each instruction is fetched from the address in the program counter, and the program counter then advances by exactly one. It wraps from 15 to 0, and it never changes in any other way.
- R3: Bits 7:4 of an instruction are the opcode and bits 3:0 are the memory address. The word 0x5D is STORE to address 13. The store strobe is raised only while a STORE (opcode 0101) executes.
- R4: LOAD (opcode 0001) copies the addressed memory word into the accumulator.
- R5: ADD (opcode 0010) adds the addressed word to the accumulator, modulo 256.
- R6: SUB (opcode 0011) subtracts the addressed word from the accumulator, modulo 256.
- R7: STORE writes the accumulator to the addressed word. `storeAddr` and `storeData` carry the address and value during the strobe. Code and data share one memory: a later LOAD returns the stored value, and a stored word can be fetched and executed as an instruction.
- R8: Opcode 1111 halts whatever its low four bits are. `halted` then stays high until reset, and the program counter and accumulator hold their values. No further stores occur.
- R9: Any opcode other than 0001, 0010, 0011, 0101 and 1111 is a no-op. It leaves the accumulator and memory unchanged and only advances the program counter.
- R10: A memory instruction takes 7 clock cycles and a no-op takes 4. `halted` rises at the end of the 4th cycle of a halt instruction, with the first fetch step in the first cycle after reset is released.
- R11: While `loadEn` is high, `loadData` is written into the memory word at `loadAddr` on the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| loadEn | input | 1 | Preload write enable, used while reset is held |
| loadAddr | input | 4 | Preload word address |
| loadData | input | 8 | Preload word value |
| pc | output | 4 | Program counter |
| acc | output | 8 | Accumulator |
| halted | output | 1 | High once a halt instruction has executed |
| storeEn | output | 1 | High in the cycle a STORE writes memory |
| storeAddr | output | 4 | Address written by the current STORE |
| storeData | output | 8 | Value written by the current STORE |

## Verification
Some properties are checked on every cycle. Reset clears the state. The program counter only ever steps by one. A store only ever happens under a STORE opcode and always carries the accumulator value. The accumulator only changes right after a LOAD, ADD or SUB. A halted processor stays frozen and makes no stores.

Other behaviours can only be shown by the bench running whole programs against values it works out itself. These are the arithmetic results and their wrap-around, a LOAD seeing an earlier STORE, self-modifying code that stores a halt word into its own path, the program counter wrapping past 15, and the exact cycle counts per instruction class.

// File: rtl/accum_cpu_pkg.sv
package accum_cpu_pkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_LOAD  = 4'b0001;
  localparam logic [OP_W-1:0] OP_ADD   = 4'b0010;
  localparam logic [OP_W-1:0] OP_SUB   = 4'b0011;
  localparam logic [OP_W-1:0] OP_STORE = 4'b0101;
  localparam logic [OP_W-1:0] OP_HALT  = 4'b1111;

  typedef enum logic [2:0] {
    ST_FETCH_ADDR,
    ST_FETCH_READ,
    ST_FETCH_LATCH,
    ST_DECODE,
    ST_EXEC_ADDR,
    ST_EXEC_DATA,
    ST_EXEC_DO,
    ST_HALTED
  } state_e;

  typedef enum logic [1:0] {
    ACC_HOLD,
    ACC_LOAD,
    ACC_ADD,
    ACC_SUB
  } acc_op_e;

  typedef struct packed {
    logic    marFromPc;
    logic    marFromCir;
    logic    mdrFromMem;
    logic    mdrFromAcc;
    logic    cirFromMdr;
    logic    pcInc;
    acc_op_e accOp;
    logic    memWrite;
  } strobe_t;

endpackage

// File: rtl/accum_cpu_mem.sv
module accum_cpu_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (loadEn) begin
      words[loadAddr] <= loadData;
    end else if (wrEn) begin
      words[wrAddr] <= wrData;
    end
  end

  // read word is captured by the data register on the next edge
  assign rdData = words[rdAddr];

endmodule

// File: rtl/accum_cpu_ctrl.sv
module accum_cpu_ctrl
  import accum_cpu_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output strobe_t         strobe,
  output logic            halted
);
  state_e state;
  state_e nextState;
  logic   isMemOp;

  assign isMemOp = (opcode == OP_LOAD) || (opcode == OP_ADD) ||
                   (opcode == OP_SUB)  || (opcode == OP_STORE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FETCH_ADDR;
    end else begin
      state <= nextState;
    end
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_FETCH_ADDR: begin
        strobe.marFromPc = 1'b1;
        nextState        = ST_FETCH_READ;
      end
      ST_FETCH_READ: begin
        strobe.mdrFromMem = 1'b1;
        nextState         = ST_FETCH_LATCH;
      end
      ST_FETCH_LATCH: begin
        strobe.cirFromMdr = 1'b1;
        strobe.pcInc      = 1'b1;
        nextState         = ST_DECODE;
      end
      ST_DECODE: begin
        if (opcode == OP_HALT) begin
          nextState = ST_HALTED;
        end else if (isMemOp) begin
          nextState = ST_EXEC_ADDR;
        end else begin
          nextState = ST_FETCH_ADDR;
        end
      end
      ST_EXEC_ADDR: begin
        strobe.marFromCir = 1'b1;
        nextState         = ST_EXEC_DATA;
      end
      ST_EXEC_DATA: begin
        if (opcode == OP_STORE) begin
          strobe.mdrFromAcc = 1'b1;
        end else begin
          strobe.mdrFromMem = 1'b1;
        end
        nextState = ST_EXEC_DO;
      end
      ST_EXEC_DO: begin
        if (opcode == OP_LOAD) begin
          strobe.accOp = ACC_LOAD;
        end else if (opcode == OP_ADD) begin
          strobe.accOp = ACC_ADD;
        end else if (opcode == OP_SUB) begin
          strobe.accOp = ACC_SUB;
        end else begin
          strobe.memWrite = 1'b1;
        end
        nextState = ST_FETCH_ADDR;
      end
      ST_HALTED: begin
        nextState = ST_HALTED;
      end
      default: begin
        nextState = ST_FETCH_ADDR;
      end
    endcase
  end

  assign halted = (state == ST_HALTED);

endmodule

// File: rtl/accum_cpu_dp.sv
module accum_cpu_dp
  import accum_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] pcQ,
  output logic [ADDR_W-1:0] marQ,
  output logic [DATA_W-1:0] mdrQ,
  output logic [DATA_W-1:0] cirQ,
  output logic [DATA_W-1:0] accQ,
  output logic [OP_W-1:0]   opcode
);
  logic [DATA_W-1:0] aluOut;

  assign opcode = cirQ[DATA_W-1 -: OP_W];

  always_comb begin
    unique case (strobe.accOp)
      ACC_LOAD: aluOut = mdrQ;
      ACC_ADD:  aluOut = accQ + mdrQ;
      ACC_SUB:  aluOut = accQ - mdrQ;
      default:  aluOut = accQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ  <= '0;
      marQ <= '0;
      mdrQ <= '0;
      cirQ <= '0;
      accQ <= '0;
    end else begin
      if (strobe.marFromPc) begin
        marQ <= pcQ;
      end else if (strobe.marFromCir) begin
        marQ <= cirQ[ADDR_W-1:0];
      end
      if (strobe.mdrFromMem) begin
        mdrQ <= memRdata;
      end else if (strobe.mdrFromAcc) begin
        mdrQ <= accQ;
      end
      if (strobe.cirFromMdr) begin
        cirQ <= mdrQ;
      end
      if (strobe.pcInc) begin
        pcQ <= pcQ + 1'b1;
      end
      accQ <= aluOut;
    end
  end

endmodule

// File: rtl/accum_cpu.sv
module accum_cpu
  import accum_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] acc,
  output logic              halted,
  output logic              storeEn,
  output logic [ADDR_W-1:0] storeAddr,
  output logic [DATA_W-1:0] storeData
);
  strobe_t           strobe;
  logic [OP_W-1:0]   opcode;
  logic [ADDR_W-1:0] marQ;
  logic [DATA_W-1:0] mdrQ;
  logic [DATA_W-1:0] cirQ;
  logic [DATA_W-1:0] memRdata;

  accum_cpu_ctrl uCtrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .strobe (strobe),
    .halted (halted)
  );

  accum_cpu_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uDp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .memRdata (memRdata),
    .pcQ      (pc),
    .marQ     (marQ),
    .mdrQ     (mdrQ),
    .cirQ     (cirQ),
    .accQ     (acc),
    .opcode   (opcode)
  );

  accum_cpu_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uMem (
    .clk      (clk),
    .loadEn   (loadEn),
    .loadAddr (loadAddr),
    .loadData (loadData),
    .wrEn     (strobe.memWrite),
    .wrAddr   (marQ),
    .wrData   (mdrQ),
    .rdAddr   (marQ),
    .rdData   (memRdata)
  );

  assign storeEn   = strobe.memWrite;
  assign storeAddr = marQ;
  assign storeData = mdrQ;

endmodule

// File: rtl/accum_cpu_chk.sv
module accum_cpu_chk
  import accum_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] pc,
  input logic [DATA_W-1:0] acc,
  input logic              halted,
  input logic              storeEn,
  input logic [DATA_W-1:0] storeData,
  input logic [DATA_W-1:0] cirQ
);
  logic [OP_W-1:0] opc;
  assign opc = cirQ[DATA_W-1 -: OP_W];

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (pc == '0 && acc == '0 && !halted && !storeEn)); // R1

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(pc) |-> pc == ADDR_W'($past(pc) + 1'b1)); // R2

  AST_STORE_OPCODE: assert property (@(posedge clk) disable iff (rst)
    storeEn |-> opc == OP_STORE); // R3

  AST_STORE_VALUE: assert property (@(posedge clk) disable iff (rst)
    storeEn |-> storeData == acc); // R7

  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc) && $stable(acc))); // R8

  AST_HALT_NO_STORE: assert property (@(posedge clk) disable iff (rst)
    halted |-> !storeEn); // R8

  AST_ACC_ARITH_ONLY: assert property (@(posedge clk) disable iff (rst)
    !$stable(acc) |-> ($past(opc) == OP_LOAD || $past(opc) == OP_ADD ||
                       $past(opc) == OP_SUB)); // R9

endmodule

bind accum_cpu accum_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uChk (
  .clk       (clk),
  .rst       (rst),
  .pc        (pc),
  .acc       (acc),
  .halted    (halted),
  .storeEn   (storeEn),
  .storeData (storeData),
  .cirQ      (cirQ)
);

// File: tb/accum_cpu_tb.sv
module accum_cpu_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       loadEn = 1'b0;
  logic [3:0] loadAddr = '0;
  logic [7:0] loadData = '0;
  logic [3:0] pc;
  logic [7:0] acc;
  logic       halted;
  logic       storeEn;
  logic [3:0] storeAddr;
  logic [7:0] storeData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct packed { logic [3:0] a; logic [7:0] d; } store_t;
  store_t sbQ[$];
  logic [7:0] img [16];

  always #2 clk = ~clk;

  accum_cpu u_dut (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadData(loadData), .pc(pc), .acc(acc), .halted(halted),
    .storeEn(storeEn), .storeAddr(storeAddr), .storeData(storeData)
  );

  task automatic check(input string req, input string what,
                       input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  task automatic expectStore(input logic [3:0] a, input logic [7:0] d);
    sbQ.push_back({a, d});
  endtask

  // monitor: pops expected stores as the design produces them (R7, R3)
  always @(negedge clk) begin
    if (!rst && storeEn) begin
      if (sbQ.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R8 unexpected store: actual addr %0d data %0d expected none",
                 storeAddr, storeData);
      end else begin
        store_t e;
        e = sbQ.pop_front();
        check("R7", "store address", storeAddr, e.a);
        check("R7", "store data", storeData, e.d);
      end
    end
  end

  task automatic clearImg();
    for (int i = 0; i < 16; i++) img[i] = 8'h00;
  endtask

  task automatic runProgram(input string name, input int expCycles,
                            input int expPc, input int expAcc);
    int cyc;
    logic [3:0] pcHold;
    logic [7:0] accHold;
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 16; i++) begin
      loadEn = 1'b1; loadAddr = 4'(i); loadData = img[i];
      @(negedge clk);
    end
    loadEn = 1'b0;
    @(negedge clk);
    check("R1", {name, " reset pc"}, pc, 0);
    check("R1", {name, " reset acc"}, acc, 0);
    check("R1", {name, " reset halted"}, halted, 0);
    check("R1", {name, " reset storeEn"}, storeEn, 0);
    rst = 1'b0;
    cyc = 0;
    while (cyc < 1000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (halted) break;
    end
    check("R10", {name, " cycles to halt"}, cyc, expCycles);
    check("R2", {name, " final pc"}, pc, expPc);
    check("R4", {name, " final acc"}, acc, expAcc);
    check("R7", {name, " stores left pending"}, sbQ.size(), 0);
    pcHold = pc; accHold = acc;
    repeat (20) @(negedge clk);
    check("R8", {name, " halted sticky"}, halted, 1);
    check("R8", {name, " pc frozen"}, pc, pcHold);
    check("R8", {name, " acc frozen"}, acc, accHold);
  endtask

  initial begin
    repeat (3) @(negedge clk);

    // A: LOAD/ADD/SUB/STORE, 0x5D = STORE 13 (R3), no-ops (R9), load after store (R7)
    clearImg();
    img[0] = 8'h1C; img[1] = 8'h2D; img[2] = 8'h5E; img[3] = 8'h3F;
    img[4] = 8'h5D; img[5] = 8'h40; img[6] = 8'h00; img[7] = 8'h1D;
    img[8] = 8'h5B; img[9] = 8'hF0;
    img[12] = 8'd25; img[13] = 8'd12; img[15] = 8'd30;
    expectStore(4'd14, 8'd37);  // R5 25+12
    expectStore(4'd13, 8'd7);   // R6 37-30, R3 0x5D
    expectStore(4'd11, 8'd7);   // R7 reload of stored word, R11 preload
    runProgram("A", 61, 10, 7);

    // B: ADD and SUB wrap modulo 256 (R5, R6)
    clearImg();
    img[0] = 8'h1E; img[1] = 8'h2F; img[2] = 8'h5D; img[3] = 8'h3C;
    img[4] = 8'h5B; img[5] = 8'hF0;
    img[12] = 8'd50; img[14] = 8'd200; img[15] = 8'd100;
    expectStore(4'd13, 8'd44);   // R5 300 mod 256
    expectStore(4'd11, 8'd250);  // R6 44-50 mod 256
    runProgram("B", 39, 6, 250);

    // C: self-modifying code stores a halt word 0xF3 into its own path (R7, R8)
    clearImg();
    img[0] = 8'h1E; img[1] = 8'h52; img[14] = 8'hF3;
    expectStore(4'd2, 8'hF3);
    runProgram("C", 18, 3, 8'hF3);

    // D: no-op codes 0,6,7,8 keep acc (R9), pc wraps 15->0 (R2)
    clearImg();
    img[1] = 8'h13; img[2] = 8'h24; img[3] = 8'h8F; img[4] = 8'h70;
    for (int i = 5; i < 15; i++) img[i] = 8'h60;
    img[15] = 8'h50;
    expectStore(4'd0, 8'hFF);   // R9 acc unchanged through no-ops
    runProgram("D", 77, 1, 8'hFF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule